// File: doc/BRIEF.md
# Memory-Mapped Integer Multiply/Divide Coprocessor

This block sits on an 8-bit host bus and takes 8x8 unsigned multiplication, division and modulo off a slow host processor. It occupies an eight-byte register window. The host stores the two operand bytes, then stores a command byte to launch either a multiply or a divide. While the operation runs, the host is free to do other work. Later it polls a status byte and reads the results from fixed offsets.

Both operations run iteratively, one bit per clock, for eight cycles. The status byte carries busy, complete and divide-error flags. When complete is set, the upper nibble also carries a fixed signature. That signature can never match the all-ones pattern of an empty, pulled-up bus, so polling software can tell a device with a finished result apart from an absent one.

Top module: `arith_copro`

## Requirements
- R1: After reset every register reads 0x00, including the status byte at offset 6.
- R2: A write to offset 0 stores operand A, and a write to offset 1 stores operand B. Both read back from the same offsets.
- R3: Writing 0x01 to offset 7 starts an unsigned multiply. When it ends, the low byte of A*B reads at offset 2 and the high byte at offset 3.
- R4: Writing 0x02 to offset 7 starts an unsigned divide. When it ends, A/B reads at offset 4 and A%B at offset 5.
- R5: Status layout is bit0 busy, bit1 complete, bit2 divide error, bit3 zero. Bits 7:4 are 0xA while complete and 0x0 otherwise. Busy reads 1 for exactly 8 cycles after the command write, and complete is set at the end of the 8th cycle.
- R6: A finished operation shows status 0xA2, or 0xA6 after a divide by zero. Status never reads 0xFF.
- R7: Any command value other than 0x01 or 0x02 is ignored. Status and results stay unchanged.
- R8: Writing either operand while idle clears the complete and error flags, so status returns to 0x00.
- R9: A divide by zero gives a quotient of 0xFF and a remainder equal to A, and sets the error bit.
- R10: A multiply leaves the quotient and remainder unchanged. A divide leaves both product bytes unchanged.
- R11: While busy, writes to the operands and to the command register are ignored.
- R12: Offset 7 reads 0x00. Writes to offsets 2 through 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for the register window |
| we | input | 1 | Write strobe, qualified by cs |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |

## Verification
The hardest state to reach is a bus access that lands while an operation is mid-flight. That includes new operand bytes, a second command, and status polls in the cycles just before and after the final iteration. The bench issues its write tasks immediately after a command, inside the eight-cycle window. It then samples status on the 7th and 8th cycle boundaries, which shows both that the late writes were dropped and that the busy edge falls exactly on time. Divide by zero and the A < B and 0xFF x 0xFF extremes are driven directly through the operand registers.

// File: rtl/arith_copro.sv
module arith_copro #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int CW = $clog2(W);
  localparam logic [AW-1:0] A_OFS = 0, B_OFS = 1, PL_OFS = 2, PH_OFS = 3,
                            Q_OFS = 4, R_OFS = 5, ST_OFS = 6, CMD_OFS = 7;
  localparam logic [W-1:0] CMD_MUL = 1, CMD_DIV = 2;
  localparam logic [3:0]   SIG = 4'hA;

  logic [W-1:0]  op_a, op_b, prod_lo, prod_hi, quo, rem, acc, sh;
  logic [CW-1:0] cnt;
  logic          busy, done, err, is_div;

  wire wr    = cs & we;
  wire start = wr && addr == CMD_OFS && !busy && (wdata == CMD_MUL || wdata == CMD_DIV);
  wire last  = busy && cnt == CW'(W-1);

  wire [W:0]   msum = {1'b0, acc} + (sh[0] ? {1'b0, op_a} : '0);
  wire [W:0]   dsh  = {acc, sh[W-1]};
  wire         dge  = dsh >= {1'b0, op_b};
  wire [W:0]   ddif = dsh - {1'b0, op_b};
  wire [W-1:0] nacc = is_div ? (dge ? ddif[W-1:0] : dsh[W-1:0]) : msum[W:1];
  wire [W-1:0] nsh  = is_div ? {sh[W-2:0], dge} : {msum[0], sh[W-1:1]};

  wire [W-1:0] status = {done ? SIG : 4'h0, 1'b0, err, done, busy};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_a <= '0; op_b <= '0; prod_lo <= '0; prod_hi <= '0;
      quo <= '0; rem <= '0; acc <= '0; sh <= '0; cnt <= '0;
      busy <= 1'b0; done <= 1'b0; err <= 1'b0; is_div <= 1'b0;
    end else begin
      if (wr && !busy && (addr == A_OFS || addr == B_OFS)) begin
        if (addr == A_OFS) op_a <= wdata;
        else               op_b <= wdata;
        done <= 1'b0;
        err  <= 1'b0;
      end
      if (start) begin
        busy   <= 1'b1;
        done   <= 1'b0;
        err    <= 1'b0;
        cnt    <= '0;
        is_div <= wdata == CMD_DIV;
        acc    <= '0;
        sh     <= wdata == CMD_DIV ? op_a : op_b;
      end else if (busy) begin
        acc <= nacc;
        sh  <= nsh;
        cnt <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (is_div) begin
            quo <= nsh;
            rem <= nacc;
            err <= op_b == '0;
          end else begin
            prod_lo <= nsh;
            prod_hi <= nacc;
          end
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_OFS:   rdata = op_a;
      B_OFS:   rdata = op_b;
      PL_OFS:  rdata = prod_lo;
      PH_OFS:  rdata = prod_hi;
      Q_OFS:   rdata = quo;
      R_OFS:   rdata = rem;
      ST_OFS:  rdata = status;
      default: rdata = '0;
    endcase
  end

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !done);

  // R5
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R9
  err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && quo == '1 && rem == op_a && op_b == '0);

  // R11
  operands_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(op_a) && $stable(op_b));

  // R6
  no_float_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status != 8'hFF);
endmodule

// File: tb/test_arith_copro.sv
module test_arith_copro;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  arith_copro i_arith_copro (.clk(clk), .rst_n(rst_n), .cs(cs), .we(we),
                             .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr = a;
    #0.5;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: offset %0d got 0x%02h expected 0x%02h", req, a, rdata, exp);
    end
  endtask

  task automatic run(input logic [7:0] cmd);
    wr(3'd7, cmd);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) chk("R1", 3'(i), 8'h00);
  endtask

  task automatic t_operands;
    wr(3'd0, 8'h3C); wr(3'd1, 8'hA5);
    chk("R2", 3'd0, 8'h3C);
    chk("R2", 3'd1, 8'hA5);
  endtask

  task automatic t_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = a * b;
    wr(3'd0, a); wr(3'd1, b);
    run(8'h01);
    chk("R3", 3'd2, p[7:0]);
    chk("R3", 3'd3, p[15:8]);
    chk("R6", 3'd6, 8'hA2);
  endtask

  task automatic t_div(input logic [7:0] a, input logic [7:0] b);
    wr(3'd0, a); wr(3'd1, b);
    run(8'h02);
    chk("R4", 3'd4, a / b);
    chk("R4", 3'd5, a % b);
    chk("R6", 3'd6, 8'hA2);
  endtask

  task automatic t_timing;
    wr(3'd0, 8'd7); wr(3'd1, 8'd9);
    chk("R8", 3'd6, 8'h00);
    wr(3'd7, 8'h01);
    chk("R5", 3'd6, 8'h01);
    repeat (7) @(negedge clk);
    chk("R5", 3'd6, 8'h01);
    @(negedge clk);
    chk("R5", 3'd6, 8'hA2);
    chk("R5", 3'd2, 8'd63);
  endtask

  task automatic t_busy_writes;
    wr(3'd0, 8'd20); wr(3'd1, 8'd3);
    wr(3'd7, 8'h02);
    wr(3'd0, 8'd99);
    wr(3'd1, 8'd50);
    wr(3'd7, 8'h01);
    repeat (5) @(negedge clk);
    chk("R11", 3'd4, 8'd6);
    chk("R11", 3'd5, 8'd2);
    chk("R11", 3'd0, 8'd20);
    chk("R11", 3'd1, 8'd3);
    chk("R11", 3'd6, 8'hA2);
  endtask

  task automatic t_divzero;
    wr(3'd0, 8'd77); wr(3'd1, 8'd0);
    run(8'h02);
    chk("R9", 3'd4, 8'hFF);
    chk("R9", 3'd5, 8'd77);
    chk("R9", 3'd6, 8'hA6);
    wr(3'd1, 8'd5);
    chk("R8", 3'd6, 8'h00);
  endtask

  task automatic t_cross;
    wr(3'd0, 8'd200); wr(3'd1, 8'd7);
    run(8'h02);
    wr(3'd0, 8'd11); wr(3'd1, 8'd13);
    run(8'h01);
    chk("R10", 3'd4, 8'd28);
    chk("R10", 3'd5, 8'd4);
    wr(3'd0, 8'd50); wr(3'd1, 8'd6);
    run(8'h02);
    chk("R10", 3'd2, 8'd143);
    chk("R10", 3'd3, 8'd0);
  endtask

  task automatic t_badcmd;
    wr(3'd0, 8'd4); wr(3'd1, 8'd4);
    wr(3'd7, 8'h03);
    chk("R7", 3'd6, 8'h00);
    wr(3'd7, 8'h00);
    wr(3'd7, 8'hFF);
    repeat (9) @(negedge clk);
    chk("R7", 3'd6, 8'h00);
    chk("R7", 3'd2, 8'd143);
    chk("R7", 3'd4, 8'd8);
  endtask

  task automatic t_ro;
    for (int i = 2; i < 7; i++) wr(3'(i), 8'h5A);
    chk("R12", 3'd2, 8'd143);
    chk("R12", 3'd3, 8'd0);
    chk("R12", 3'd4, 8'd8);
    chk("R12", 3'd5, 8'd2);
    chk("R12", 3'd6, 8'h00);
    chk("R12", 3'd7, 8'h00);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_operands;
    t_mul(8'd12, 8'd11);
    t_mul(8'hFF, 8'hFF);
    t_mul(8'd0, 8'd93);
    t_div(8'd250, 8'd7);
    t_div(8'd5, 8'd9);
    t_div(8'hFF, 8'd1);
    t_timing;
    t_busy_writes;
    t_divzero;
    t_cross;
    t_badcmd;
    t_ro;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    finish_run;
  end
endmodule